// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

This block holds a set of independent decrementing timers behind a plain register bus. Each channel has a 32-bit counter, a reload value, four control bits and one interrupt status bit. Each channel drives its own interrupt line. Software never writes the control bits directly. It raises bits through a set port and lowers them through a separate clear port. This means two agents can change different bits of the same channel without a read-modify-write race.

Every channel owns a 64-byte window in the bus address space. The upper address bits select the channel and the low six bits select the register. A channel counts on every bus clock, or only on the cycles where the external 1 MHz tick enable is high; this choice is made per channel. When a running counter is at zero and takes a tick, it raises its status bit. It then either reloads and keeps running, or stops.

Read data is combinational: it is valid in the same cycle that `bus_rd` is high.

Top module: `tmr_bank`

## Requirements
- R1: Address decode and register map.
  - The channel index is `bus_addr[8:6]` and the register offset is `bus_addr[5:0]`.
  - Offset 0x00 returns the current count, is read-only, and ignores writes.
  - Offset 0x04 is the reload value and can be read and written.
  - Offset 0x10 reads back the control bits in [3:0] and the status bit in bit 4.
  - Offset 0x14 and every other offset read as zero.
  - Read data appears in the same cycle as `bus_rd`.
- R2: A write to offset 0x10 sets each control bit whose data bit in [3:0] is 1. Bits written as 0 keep their value.
- R3: A write to offset 0x14 clears each control bit whose data bit in [3:0] is 1. When data bit 2 is 1, the status bit is also cleared.
- R4: The control bits are: bit 0 run, bit 1 tick select, bit 2 interrupt enable, bit 3 auto-reload. When run changes from 0 to 1, the counter loads the reload value on that edge. Setting run while it is already 1 does not reload the counter.
- R5: While run is 1, the counter drops by one on each tick. A tick is every clock when tick select is 0, and each clock with `tick_1us` high when tick select is 1. With tick select at 1 and `tick_1us` low, the count holds.
- R6: A tick that arrives while the count is zero raises the status bit. With auto-reload set, the counter then reloads and keeps running, which gives a period of reload+1 ticks. Without auto-reload, run clears and the count stays at zero.
- R7: If an expiry and a status-clearing write to 0x14 land in the same cycle, the status bit ends up set.
- R8: `irq[n]` is high exactly while channel n has both its status bit and its interrupt enable at 1.
- R9: After reset, every count, reload value, control bit, status bit and interrupt output is zero.
- R10: A bus access aimed at one channel leaves every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | 1 MHz tick enable, one clock wide per tick |
| bus_addr | input | 9 | Byte address: channel in [8:6], register in [5:0] |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq | output | 8 | Per-channel interrupt lines |

## Verification
Two events can collide in the same cycle: a counter expiring, and software clearing that channel's status through the clear port. The bench runs an auto-reload channel and times a clear write carrying bit 2 so that the write edge is the expiry edge. It expects status to read back as 1 and interrupt enable as 0, which is R7. A later clear on a non-expiry edge must then drop the status bit, which shows the clear path works on its own.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Control bits, bit 0 first: run, tick select, interrupt enable, auto-reload
    typedef struct packed {
        logic autold;
        logic ien;
        logic tsel;
        logic run;
    } tmr_ctrl_t;

    localparam int CTRL_W   = 4;
    localparam int WIN_BITS = 6;

    typedef enum logic [WIN_BITS-1:0] {
        OFF_COUNT  = 6'h00,
        OFF_RELOAD = 6'h04,
        OFF_SETST  = 6'h10,
        OFF_CLR    = 6'h14
    } tmr_off_e;

    typedef struct packed {
        logic set_wr;
        logic clr_wr;
        logic rld_wr;
    } tmr_wcmd_t;

    function automatic tmr_ctrl_t ctrl_apply(tmr_ctrl_t cur,
                                             logic [CTRL_W-1:0] setm,
                                             logic [CTRL_W-1:0] clrm);
        return tmr_ctrl_t'((CTRL_W'(cur) | setm) & ~clrm);
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 8,
    parameter int IDX_W   = 3,
    parameter int ADDR_W  = IDX_W + WIN_BITS
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          wr,
    output tmr_wcmd_t [NUM_TMR-1:0]       wcmd,
    output logic [IDX_W-1:0]              idx,
    output logic [WIN_BITS-1:0]           off,
    output logic                          hit
);
    always_comb begin
        idx = addr[ADDR_W-1:WIN_BITS];
        off = addr[WIN_BITS-1:0];
        hit = (int'(idx) < NUM_TMR);
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_sel
        logic mine;
        assign mine = wr && hit && (idx == IDX_W'(g));
        assign wcmd[g].set_wr = mine && (off == OFF_SETST);
        assign wcmd[g].clr_wr = mine && (off == OFF_CLR);
        assign wcmd[g].rld_wr = mine && (off == OFF_RELOAD);
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1us,
    input  tmr_wcmd_t         wcmd,
    input  logic [CTRL_W-1:0] wmask,
    input  logic [CNT_W-1:0]  wval,
    output tmr_ctrl_t         ctrl_q,
    output logic              stat_q,
    output logic [CNT_W-1:0]  count_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              irq
);
    logic             tick_en, expire, stat_d;
    tmr_ctrl_t        ctrl_d;
    logic [CNT_W-1:0] count_d, reload_d;

    always_comb begin
        tick_en = ctrl_q.run && (ctrl_q.tsel ? tick_1us : 1'b1);
        expire  = tick_en && (count_q == '0);

        ctrl_d = ctrl_apply(ctrl_q,
                            wcmd.set_wr ? wmask : '0,
                            wcmd.clr_wr ? wmask : '0);
        if (expire && !ctrl_q.autold) ctrl_d.run = 1'b0;

        // expiry outranks a simultaneous acknowledge
        stat_d = (stat_q && !(wcmd.clr_wr && wmask[2])) || expire;

        if (!ctrl_q.run && ctrl_d.run)
            count_d = reload_q;
        else if (expire)
            count_d = ctrl_q.autold ? reload_q : '0;
        else if (tick_en)
            count_d = count_q - 1'b1;
        else
            count_d = count_q;

        reload_d = wcmd.rld_wr ? wval : reload_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            stat_q   <= 1'b0;
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            ctrl_q   <= ctrl_d;
            stat_q   <= stat_d;
            count_q  <= count_d;
            reload_q <= reload_d;
        end
    end

    assign irq = stat_q && ctrl_q.ien;
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 8,
    parameter int IDX_W   = 3,
    parameter int CNT_W   = 32,
    parameter int DATA_W  = 32
) (
    input  logic                          rd,
    input  logic                          hit,
    input  logic [IDX_W-1:0]              idx,
    input  logic [WIN_BITS-1:0]           off,
    input  tmr_ctrl_t [NUM_TMR-1:0]       ctrl_v,
    input  logic [NUM_TMR-1:0]            stat_v,
    input  logic [NUM_TMR-1:0][CNT_W-1:0] count_v,
    input  logic [NUM_TMR-1:0][CNT_W-1:0] reload_v,
    output logic [DATA_W-1:0]             rdata
);
    always_comb begin
        rdata = '0;
        if (rd && hit) begin
            case (off)
                OFF_COUNT:  rdata = DATA_W'(count_v[idx]);
                OFF_RELOAD: rdata = DATA_W'(reload_v[idx]);
                OFF_SETST:  rdata = DATA_W'({stat_v[idx], CTRL_W'(ctrl_v[idx])});
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 8,
    parameter int CNT_W   = 32,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1,
    localparam int ADDR_W = IDX_W + WIN_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_1us,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_TMR-1:0] irq
);
    tmr_wcmd_t [NUM_TMR-1:0]       wcmd;
    logic [IDX_W-1:0]              idx;
    logic [WIN_BITS-1:0]           off;
    logic                          hit;
    tmr_ctrl_t [NUM_TMR-1:0]       ctrl_v;
    logic [NUM_TMR-1:0]            stat_v;
    logic [NUM_TMR-1:0][CNT_W-1:0] count_v;
    logic [NUM_TMR-1:0][CNT_W-1:0] reload_v;

    tmr_decode #(.NUM_TMR(NUM_TMR), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .wcmd(wcmd), .idx(idx), .off(off), .hit(hit)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick_1us (tick_1us),
            .wcmd     (wcmd[g]),
            .wmask    (bus_wdata[CTRL_W-1:0]),
            .wval     (bus_wdata[CNT_W-1:0]),
            .ctrl_q   (ctrl_v[g]),
            .stat_q   (stat_v[g]),
            .count_q  (count_v[g]),
            .reload_q (reload_v[g]),
            .irq      (irq[g])
        );
    end

    tmr_rdmux #(.NUM_TMR(NUM_TMR), .IDX_W(IDX_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
        .rd(bus_rd), .hit(hit), .idx(idx), .off(off), .ctrl_v(ctrl_v),
        .stat_v(stat_v), .count_v(count_v), .reload_v(reload_v), .rdata(bus_rdata)
    );
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 8,
    parameter int CNT_W   = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 9
) (
    input logic                          clk,
    input logic                          rst,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic                          bus_wr,
    input tmr_ctrl_t [NUM_TMR-1:0]       ctrl_v,
    input logic [NUM_TMR-1:0]            stat_v,
    input logic [NUM_TMR-1:0][CNT_W-1:0] count_v,
    input logic [NUM_TMR-1:0][CNT_W-1:0] reload_v,
    input logic [NUM_TMR-1:0]            irq
);
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_p
        localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'((i << WIN_BITS) | 32'h14);

        a_r4_load_on_start: assert property (@(posedge clk) disable iff (rst)
            (!ctrl_v[i].run ##1 ctrl_v[i].run) |-> count_v[i] == $past(reload_v[i]));

        a_r5_step: assert property (@(posedge clk) disable iff (rst)
            (ctrl_v[i].run && !ctrl_v[i].tsel && count_v[i] != '0)
            |=> count_v[i] == $past(count_v[i]) - 1'b1);

        a_r6_expire_flag: assert property (@(posedge clk) disable iff (rst)
            (ctrl_v[i].run && !ctrl_v[i].tsel && count_v[i] == '0) |=> stat_v[i]);

        a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
            (ctrl_v[i].run && !ctrl_v[i].tsel && !ctrl_v[i].autold && count_v[i] == '0)
            |=> !ctrl_v[i].run);

        a_r3_status_fall: assert property (@(posedge clk) disable iff (rst)
            $fell(stat_v[i]) |-> $past(bus_wr && bus_addr == CLR_ADDR && bus_wdata[2]));

        a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[i]) |-> stat_v[i]);
    end
endmodule

bind tmr_bank tmr_bank_chk #(
    .NUM_TMR(NUM_TMR), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .ctrl_v(ctrl_v), .stat_v(stat_v), .count_v(count_v), .reload_v(reload_v), .irq(irq)
);

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;
    localparam int AW = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1us = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    tmr_bank u_dut (
        .clk(clk), .rst(rst), .tick_1us(tick_1us), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [AW-1:0] ad(int ch, int off);
        return AW'((ch << 6) | off);
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // all tasks are entered on a falling edge and return on the next one
    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [AW-1:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_pulse();
        tick_1us = 1'b1;
        @(negedge clk);
        tick_1us = 1'b0;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_rd) begin
                if (exp_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R1 unexpected read got=%h exp=none", bus_rdata);
                end else begin
                    check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        checks++; failures++;
        $display("FAIL watchdog got=timeout exp=finish");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;

        // R9 reset state
        bus_read(ad(0, 'h00), 32'h0, "R9 count0 after reset");
        bus_read(ad(0, 'h10), 32'h0, "R9 ctrl0 after reset");
        bus_read(ad(7, 'h04), 32'h0, "R9 reload7 after reset");
        check("R9 irq after reset", 32'(irq), 32'h0);

        // channel 0 one-shot on bus clock
        bus_write(ad(0, 'h04), 32'd5);
        bus_read(ad(0, 'h04), 32'd5, "R1 reload0 readback");
        bus_write(ad(0, 'h10), 32'h5);
        bus_read(ad(0, 'h00), 32'd5, "R4 load on start");
        bus_read(ad(0, 'h00), 32'd4, "R5 decrement");
        bus_read(ad(0, 'h00), 32'd3, "R5 decrement");
        bus_read(ad(0, 'h10), 32'h05, "R2 set bits");
        idle(3);
        check("R8 irq0 high", 32'(irq[0]), 32'h1);
        bus_read(ad(0, 'h10), 32'h14, "R6 one-shot expiry");
        bus_read(ad(0, 'h00), 32'd0, "R6 one-shot holds zero");
        bus_write(ad(0, 'h14), 32'h4);
        check("R8 irq0 low after clear", 32'(irq[0]), 32'h0);
        bus_read(ad(0, 'h10), 32'h0, "R3 clear ien and status");

        bus_write(ad(0, 'h10), 32'h4);
        bus_write(ad(0, 'h10), 32'h0);
        bus_read(ad(0, 'h10), 32'h4, "R2 zero bits no effect");
        check("R8 ien without status", 32'(irq[0]), 32'h0);
        bus_read(ad(0, 'h14), 32'h0, "R1 clear port reads zero");
        bus_read(ad(0, 'h08), 32'h0, "R1 unmapped offset");
        bus_write(ad(0, 'h00), 32'h1234);
        bus_read(ad(0, 'h00), 32'h0, "R1 count read-only");

        // channel 3 auto-reload and the expiry/clear collision
        bus_write(ad(3, 'h04), 32'd2);
        bus_write(ad(3, 'h10), 32'hD);
        bus_read(ad(3, 'h00), 32'd2, "R4 load ch3");
        bus_read(ad(3, 'h00), 32'd1, "R5 ch3 step");
        bus_read(ad(3, 'h00), 32'd0, "R5 ch3 zero");
        bus_read(ad(3, 'h00), 32'd2, "R6 auto reload");
        bus_read(ad(3, 'h10), 32'h1D, "R6 status and still running");
        bus_read(ad(3, 'h00), 32'd0, "R6 second period");
        bus_read(ad(3, 'h00), 32'd2, "R6 second reload");
        idle(1);
        bus_write(ad(3, 'h14), 32'h4);
        check("R8 irq3 low with ien cleared", 32'(irq[3]), 32'h0);
        bus_read(ad(3, 'h10), 32'h19, "R7 expiry beats clear");
        bus_write(ad(3, 'h14), 32'h4);
        bus_read(ad(3, 'h10), 32'h09, "R3 status clear");
        bus_write(ad(3, 'h14), 32'hF);
        bus_read(ad(3, 'h10), 32'h0, "R3 clear all");
        bus_read(ad(3, 'h00), 32'd1, "R3 stopped count holds");
        bus_read(ad(0, 'h10), 32'h4, "R10 ch0 untouched");

        // channel 5 on the external tick
        bus_write(ad(5, 'h04), 32'd3);
        bus_write(ad(5, 'h10), 32'h3);
        idle(3);
        bus_read(ad(5, 'h00), 32'd3, "R5 no tick no count");
        tick_pulse();
        bus_read(ad(5, 'h00), 32'd2, "R5 tick counts");
        bus_write(ad(5, 'h10), 32'h1);
        bus_read(ad(5, 'h00), 32'd2, "R4 no reload when running");
        tick_pulse();
        tick_pulse();
        tick_pulse();
        bus_read(ad(5, 'h10), 32'h12, "R6 tick expiry stops");
        check("R8 no irq without enable", 32'(irq), 32'h0);

        bus_write(ad(7, 'h04), 32'hFFFF_FFFF);
        bus_read(ad(7, 'h04), 32'hFFFF_FFFF, "R1 last window");
        bus_read(ad(6, 'h04), 32'h0, "R10 neighbour reload");

        idle(2);
        check("R1 scoreboard drained", 32'(exp_q.size()), 32'h0);
        finish_run();
    end
endmodule